// File: doc/BRIEF.md
# PID-Tagged Translation Cache

This block is a small, fully associative translation cache that sits beside a processor's load, store and instruction-fetch path. Each lookup presents a 32-bit virtual address, the identifier of the process that is running, and the kind of access. The upper 20 bits of the address (the virtual page number, for 4 KB pages) are compared against every cached mapping at once. The lower 12 bits pass through unchanged. The cache answers in the same cycle with a hit flag, a protection-fault flag and the physical address.

Every mapping carries the identifier of the process that owns it. Mappings from several processes can therefore live side by side, and a page-number match that belongs to another process counts as a miss. Each mapping also holds read, write and execute rights, and these are checked against the access kind. After a miss, the walker outside this block writes the missing mapping through the refill port. A flush input drops every mapping.

Top module: `pid_tlb`

## Requirements
- R1: On a hit, `lk_paddr` equals the cached frame number in the upper 20 bits, joined with bits 11:0 of `lk_vaddr` unchanged in the low 12 bits.
- R2: Lookup is fully associative. A mapping written into any slot hits for its page number, with no constraint from the address bits on which slot may hold it.
- R3: A hit needs both the page number and the process identifier to match. A page-number match whose stored identifier differs from `lk_pid` gives `lk_hit`=0 and `lk_fault`=0.
- R4: `lk_kind` encodes the access as 0 for a load, 1 for a store, 2 for an instruction fetch and 3 for reserved. `fill_rwx` bit 2 grants read, bit 1 grants write and bit 0 grants execute. A load needs read, a store needs write and a fetch needs execute. Code 3 never has its right. A match whose right is missing gives `lk_fault`=1 and `lk_hit`=0.
- R5: When no valid mapping matches, both `lk_hit` and `lk_fault` are 0. `lk_hit` and `lk_fault` are never 1 together.
- R6: The lookup is combinational. A refill becomes visible only after the next rising clock edge, so a lookup in the same cycle as the refill still misses.
- R7: A refill with no existing match goes into the lowest-numbered invalid slot, and the replacement pointer does not move.
- R8: When every slot is valid, a refill with no existing match replaces the slot named by the replacement pointer. The pointer then advances by one and wraps from the last slot to slot 0.
- R9: A refill whose page number and process identifier already match a valid slot rewrites that slot in place. It creates no second copy and leaves the pointer where it was.
- R10: A flush clears every valid flag at the next edge and leaves the replacement pointer unchanged. A refill in the same cycle as a flush is dropped.
- R11: After reset every slot is invalid and the replacement pointer is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| lk_vaddr | input | VA_W (32) | Virtual address being translated |
| lk_pid | input | PID_W (8) | Identifier of the running process |
| lk_kind | input | 2 | Access kind: 0 load, 1 store, 2 fetch, 3 reserved |
| lk_hit | output | 1 | Matching mapping found and the access is permitted |
| lk_fault | output | 1 | Matching mapping found but the needed right is missing |
| lk_paddr | output | PFN_W+PAGE_BITS (32) | Physical address; meaningful only when lk_hit is 1 |
| fill_en | input | 1 | Write a mapping at the next edge |
| fill_vpn | input | VA_W-PAGE_BITS (20) | Virtual page number of the new mapping |
| fill_pid | input | PID_W (8) | Owning process of the new mapping |
| fill_pfn | input | PFN_W (20) | Physical frame number of the new mapping |
| fill_rwx | input | 3 | Rights: bit 2 read, bit 1 write, bit 0 execute |
| flush | input | 1 | Invalidate every mapping at the next edge |

## Verification
The bench builds the cache with 8 slots and a 4-bit process identifier. With these values, all 16 identifiers can be swept against a single cached page. All 8 rights combinations can be crossed with all 4 access kinds, and a full rotation of the replacement pointer, plus a wrap, fits in a few dozen refills. Because a flush does not reset the pointer, the bench can leave the pointer away from 0, refill an emptied cache, and then see from which mapping is evicted next that invalid slots were taken first and the pointer was left alone.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_e;

    localparam int RIGHT_R = 2;
    localparam int RIGHT_W = 1;
    localparam int RIGHT_X = 0;

    function automatic logic right_ok(acc_e kind, logic [2:0] rwx);
        logic ok;
        case (kind)
            ACC_LOAD:  ok = rwx[RIGHT_R];
            ACC_STORE: ok = rwx[RIGHT_W];
            ACC_FETCH: ok = rwx[RIGHT_X];
            default:   ok = 1'b0;
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/tlb_match.sv
module tlb_match #(
    parameter int ENTRIES = 16,
    parameter int VPN_W   = 20,
    parameter int PID_W   = 8
) (
    input  logic [ENTRIES-1:0]            valid,
    input  logic [ENTRIES-1:0][VPN_W-1:0] vpn,
    input  logic [ENTRIES-1:0][PID_W-1:0] pid,
    input  logic [VPN_W-1:0]              key_vpn,
    input  logic [PID_W-1:0]              key_pid,
    output logic [ENTRIES-1:0]            hit_vec
);

    // One comparator pair per slot, all evaluated in parallel.
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        logic vpn_eq;
        logic pid_eq;
        assign vpn_eq     = (vpn[g] == key_vpn);
        assign pid_eq     = (pid[g] == key_pid);
        assign hit_vec[g] = valid[g] & vpn_eq & pid_eq;
    end

endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
    parameter int ENTRIES = 16,
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input  logic [ENTRIES-1:0] valid,
    input  logic [IDX_W-1:0]   ptr,
    output logic [IDX_W-1:0]   slot,
    output logic               use_ptr
);

    logic [IDX_W-1:0] free_idx;
    logic             any_free;

    // Lowest-numbered invalid slot wins.
    always_comb begin
        free_idx = '0;
        any_free = 1'b0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!valid[i]) begin
                free_idx = IDX_W'(i);
                any_free = 1'b1;
            end
        end
    end

    assign use_ptr = ~any_free;
    assign slot    = any_free ? free_idx : ptr;

endmodule

// File: rtl/tlb_perm.sv
module tlb_perm (
    input  logic [1:0] kind,
    input  logic [2:0] rwx,
    output logic       ok
);
    import tlb_pkg::*;

    assign ok = right_ok(acc_e'(kind), rwx);

endmodule

// File: rtl/pid_tlb.sv
module pid_tlb #(
    parameter int VA_W      = 32,
    parameter int PAGE_BITS = 12,
    parameter int PFN_W     = 20,
    parameter int PID_W     = 8,
    parameter int ENTRIES   = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [VA_W-1:0]           lk_vaddr,
    input  logic [PID_W-1:0]          lk_pid,
    input  logic [1:0]                lk_kind,
    output logic                      lk_hit,
    output logic                      lk_fault,
    output logic [PFN_W+PAGE_BITS-1:0] lk_paddr,
    input  logic                      fill_en,
    input  logic [VA_W-PAGE_BITS-1:0] fill_vpn,
    input  logic [PID_W-1:0]          fill_pid,
    input  logic [PFN_W-1:0]          fill_pfn,
    input  logic [2:0]                fill_rwx,
    input  logic                      flush
);

    localparam int VPN_W = VA_W - PAGE_BITS;
    localparam int IDX_W = $clog2(ENTRIES);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

    typedef struct packed {
        logic [ENTRIES-1:0]            valid;
        logic [IDX_W-1:0]              ptr;
        logic [ENTRIES-1:0][VPN_W-1:0] vpn;
        logic [ENTRIES-1:0][PID_W-1:0] pid;
        logic [ENTRIES-1:0][PFN_W-1:0] pfn;
        logic [ENTRIES-1:0][2:0]       rwx;
    } tlb_state_t;

    tlb_state_t st_d, st_q;

    // ---------------- lookup side ----------------
    logic [VPN_W-1:0]     lk_vpn;
    logic [PAGE_BITS-1:0] lk_off;
    logic [ENTRIES-1:0]   lk_match;
    logic [PFN_W-1:0]     sel_pfn;
    logic [2:0]           sel_rwx;
    logic                 sel_any;
    logic                 perm_ok;

    assign lk_vpn = lk_vaddr[VA_W-1:PAGE_BITS];
    assign lk_off = lk_vaddr[PAGE_BITS-1:0];

    tlb_match #(
        .ENTRIES (ENTRIES),
        .VPN_W   (VPN_W),
        .PID_W   (PID_W)
    ) u_lk_match (
        .valid   (st_q.valid),
        .vpn     (st_q.vpn),
        .pid     (st_q.pid),
        .key_vpn (lk_vpn),
        .key_pid (lk_pid),
        .hit_vec (lk_match)
    );

    // Refill never duplicates a mapping, so at most one slot matches
    // and an OR-reduction serves as the read mux.
    always_comb begin
        sel_pfn = '0;
        sel_rwx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (lk_match[i]) begin
                sel_pfn = sel_pfn | st_q.pfn[i];
                sel_rwx = sel_rwx | st_q.rwx[i];
            end
        end
        sel_any = |lk_match;
    end

    tlb_perm u_perm (
        .kind (lk_kind),
        .rwx  (sel_rwx),
        .ok   (perm_ok)
    );

    assign lk_hit   = sel_any & perm_ok;
    assign lk_fault = sel_any & ~perm_ok;
    assign lk_paddr = {sel_pfn, lk_off};

    // ---------------- refill side ----------------
    logic [ENTRIES-1:0] fill_match;
    logic [IDX_W-1:0]   hit_slot;
    logic [IDX_W-1:0]   vic_slot;
    logic               vic_use_ptr;

    tlb_match #(
        .ENTRIES (ENTRIES),
        .VPN_W   (VPN_W),
        .PID_W   (PID_W)
    ) u_fill_match (
        .valid   (st_q.valid),
        .vpn     (st_q.vpn),
        .pid     (st_q.pid),
        .key_vpn (fill_vpn),
        .key_pid (fill_pid),
        .hit_vec (fill_match)
    );

    always_comb begin
        hit_slot = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (fill_match[i]) begin
                hit_slot = IDX_W'(i);
            end
        end
    end

    tlb_victim #(
        .ENTRIES (ENTRIES),
        .IDX_W   (IDX_W)
    ) u_victim (
        .valid   (st_q.valid),
        .ptr     (st_q.ptr),
        .slot    (vic_slot),
        .use_ptr (vic_use_ptr)
    );

    // ---------------- next state ----------------
    always_comb begin
        logic [IDX_W-1:0] wr_slot;
        st_d    = st_q;
        wr_slot = vic_slot;
        if (flush) begin
            st_d.valid = '0;
        end else if (fill_en) begin
            if (|fill_match) begin
                wr_slot = hit_slot;
            end else if (vic_use_ptr) begin
                st_d.ptr = (st_q.ptr == LAST_IDX) ? '0 : st_q.ptr + 1'b1;
            end
            st_d.valid[wr_slot] = 1'b1;
            st_d.vpn[wr_slot]   = fill_vpn;
            st_d.pid[wr_slot]   = fill_pid;
            st_d.pfn[wr_slot]   = fill_pfn;
            st_d.rwx[wr_slot]   = fill_rwx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/tlb_chk.sv
module tlb_chk #(
    parameter int ENTRIES   = 16,
    parameter int VA_W      = 32,
    parameter int PAGE_BITS = 12,
    parameter int PA_W      = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic [VA_W-1:0]    lk_vaddr,
    input logic [PA_W-1:0]    lk_paddr,
    input logic               lk_hit,
    input logic               lk_fault,
    input logic               fill_en,
    input logic               flush,
    input logic [ENTRIES-1:0] valid_q
);

    // R5
    hit_fault_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(lk_hit && lk_fault));

    // R1
    offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> (lk_paddr[PAGE_BITS-1:0] == lk_vaddr[PAGE_BITS-1:0]));

    // R10
    flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (valid_q == '0 && !lk_hit && !lk_fault));

    // R6
    fill_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_en && !flush) |=> (valid_q != '0));

    // R9
    no_loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !flush |=> ($countones(valid_q) >= $countones($past(valid_q))));

    // R11
    reset_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (valid_q == '0));

endmodule

bind pid_tlb tlb_chk #(
    .ENTRIES   (ENTRIES),
    .VA_W      (VA_W),
    .PAGE_BITS (PAGE_BITS),
    .PA_W      (PFN_W + PAGE_BITS)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .lk_vaddr (lk_vaddr),
    .lk_paddr (lk_paddr),
    .lk_hit   (lk_hit),
    .lk_fault (lk_fault),
    .fill_en  (fill_en),
    .flush    (flush),
    .valid_q  (st_q.valid)
);

// File: tb/pid_tlb_tb.sv
module pid_tlb_tb;

    localparam int N     = 8;
    localparam int PID_W = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] lk_vaddr = '0;
    logic [PID_W-1:0] lk_pid = '0;
    logic [1:0]  lk_kind = '0;
    logic        lk_hit, lk_fault;
    logic [31:0] lk_paddr;
    logic        fill_en = 1'b0;
    logic [19:0] fill_vpn = '0;
    logic [PID_W-1:0] fill_pid = '0;
    logic [19:0] fill_pfn = '0;
    logic [2:0]  fill_rwx = '0;
    logic        flush = 1'b0;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    pid_tlb #(
        .PID_W   (PID_W),
        .ENTRIES (N)
    ) u_dut (
        .clk, .rst_n, .lk_vaddr, .lk_pid, .lk_kind, .lk_hit, .lk_fault,
        .lk_paddr, .fill_en, .fill_vpn, .fill_pid, .fill_pfn, .fill_rwx, .flush
    );

    function automatic logic [19:0] vpn_of(int k);
        return 20'h12340 + 20'(k * 'h111);
    endfunction

    function automatic logic [19:0] pfn_of(int k);
        return 20'hA0000 + 20'(k * 3);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic look(input logic [19:0] vpn, input logic [11:0] off,
                        input logic [PID_W-1:0] pid, input logic [1:0] kind);
        @(negedge clk);
        lk_vaddr = {vpn, off};
        lk_pid   = pid;
        lk_kind  = kind;
        #1;
    endtask

    task automatic want_hit(input string req, input logic [19:0] vpn,
                            input logic [PID_W-1:0] pid, input logic [19:0] pfn);
        logic [11:0] off;
        off = 12'(vpn * 7) ^ 12'h5A3;
        look(vpn, off, pid, 2'd0);
        check(req, {30'b0, lk_hit, lk_fault}, 32'b10);
        check(req, lk_paddr, {pfn, off});
    endtask

    task automatic want_miss(input string req, input logic [19:0] vpn,
                             input logic [PID_W-1:0] pid);
        look(vpn, 12'h0F0, pid, 2'd0);
        check(req, {30'b0, lk_hit, lk_fault}, 32'b00);
    endtask

    task automatic fill(input logic [19:0] vpn, input logic [PID_W-1:0] pid,
                        input logic [19:0] pfn, input logic [2:0] rwx);
        @(negedge clk);
        fill_en  = 1'b1;
        fill_vpn = vpn;
        fill_pid = pid;
        fill_pfn = pfn;
        fill_rwx = rwx;
        @(negedge clk);
        fill_en  = 1'b0;
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        // R11: reset state
        repeat (3) @(negedge clk);
        look(20'h0, 12'h0, '0, 2'd0);
        check("R11 in reset", {30'b0, lk_hit, lk_fault}, 32'b00);
        rst_n = 1'b1;
        want_miss("R11 after reset", vpn_of(0), 4'd0);

        // R6: refill not visible in its own cycle, visible after edge
        @(negedge clk);
        fill_en = 1'b1; fill_vpn = vpn_of(0); fill_pid = 4'd0;
        fill_pfn = pfn_of(0); fill_rwx = 3'b111;
        lk_vaddr = {vpn_of(0), 12'h123}; lk_pid = 4'd0; lk_kind = 2'd0;
        #1;
        check("R6 same cycle miss", {30'b0, lk_hit, lk_fault}, 32'b00);
        @(negedge clk);
        fill_en = 1'b0;
        #1;
        check("R6 next cycle hit", {31'b0, lk_hit}, 32'b1);
        check("R1 paddr", lk_paddr, {pfn_of(0), 12'h123});

        // R2/R1: fill all slots, each hits
        for (int i = 1; i < N; i++) fill(vpn_of(i), PID_W'(i), pfn_of(i), 3'b111);
        for (int i = 0; i < N; i++) want_hit("R2 R1 slot hit", vpn_of(i), PID_W'(i), pfn_of(i));

        // R3: sweep every process id against one page
        for (int p = 0; p < 16; p++) begin
            look(vpn_of(0), 12'h040, PID_W'(p), 2'd0);
            check("R3 pid sweep", {30'b0, lk_hit, lk_fault}, (p == 0) ? 32'b10 : 32'b00);
        end
        // R5: unknown page
        want_miss("R5 unknown page", 20'hFFFFF, 4'd3);

        // R4/R9: rewrite slot holding page 3 with every rights code
        for (int c = 0; c < 8; c++) begin
            fill(vpn_of(3), 4'd3, pfn_of(3) + 20'(c), 3'(c));
            for (int kd = 0; kd < 4; kd++) begin
                logic ok;
                ok = (kd == 0) ? c[2] : (kd == 1) ? c[1] : (kd == 2) ? c[0] : 1'b0;
                look(vpn_of(3), 12'h777, 4'd3, 2'(kd));
                check("R4 rights", {30'b0, lk_hit, lk_fault}, ok ? 32'b10 : 32'b01);
                if (ok) check("R4 R9 paddr", lk_paddr, {pfn_of(3) + 20'(c), 12'h777});
            end
        end
        fill(vpn_of(3), 4'd3, pfn_of(3), 3'b111);
        for (int i = 0; i < N; i++) want_hit("R9 no eviction", vpn_of(i), PID_W'(i), pfn_of(i));

        // R8: round robin from pointer 0
        fill(20'h50000, 4'd9, 20'h70000, 3'b111);
        want_miss("R8 slot0 evicted", vpn_of(0), 4'd0);
        for (int i = 1; i < N; i++) want_hit("R8 others kept", vpn_of(i), PID_W'(i), pfn_of(i));
        for (int j = 1; j < N; j++) fill(20'h50000 + 20'(j), 4'd9, 20'h70000 + 20'(j), 3'b111);
        for (int i = 1; i < N; i++) want_miss("R8 all replaced", vpn_of(i), PID_W'(i));
        fill(20'h60000, 4'd10, 20'h60006, 3'b111);
        want_miss("R8 wrap evicts slot0", 20'h50000, 4'd9);
        for (int j = 1; j < N; j++) want_hit("R8 wrap keeps", 20'h50000 + 20'(j), 4'd9, 20'h70000 + 20'(j));
        want_hit("R8 wrap new", 20'h60000, 4'd10, 20'h60006);

        // R10: flush with simultaneous refill; refill dropped
        @(negedge clk);
        flush = 1'b1; fill_en = 1'b1; fill_vpn = 20'h61000; fill_pid = 4'd11;
        fill_pfn = 20'h00011; fill_rwx = 3'b111;
        @(negedge clk);
        flush = 1'b0; fill_en = 1'b0;
        want_miss("R10 dropped refill", 20'h61000, 4'd11);
        want_miss("R10 flushed", 20'h60000, 4'd10);
        want_miss("R10 flushed", 20'h50003, 4'd9);

        // R7: invalid slots first, pointer (now 1) left alone
        for (int j = 0; j < N; j++) fill(20'h40000 + 20'(j), 4'd2, 20'h30000 + 20'(j), 3'b111);
        for (int j = 0; j < N; j++) want_hit("R7 refill after flush", 20'h40000 + 20'(j), 4'd2, 20'h30000 + 20'(j));
        fill(20'h41000, 4'd2, 20'h31000, 3'b111);
        want_miss("R7 R10 pointer kept, slot1 evicted", 20'h40001, 4'd2);
        want_hit("R7 slot0 kept", 20'h40000, 4'd2, 20'h30000);
        for (int j = 2; j < N; j++) want_hit("R7 others kept", 20'h40000 + 20'(j), 4'd2, 20'h30000 + 20'(j));
        want_hit("R8 new mapping", 20'h41000, 4'd2, 20'h31000);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule